// File: doc/BRIEF.md
# Non-Preemptive Priority Channel Arbiter

This block decides which of six transfer channels owns a single bus master port. Each channel presents a request bit and a 3-bit priority. Priority 5 is the most urgent and priority 0 the least. When the port is free, the arbiter grants the requesting channel with the highest priority. It then holds that grant until the bus side pulses a transfer-done strobe, which marks the end of one single beat or one whole burst.

A transfer that is already running is never cut short. A more urgent request that arrives in the middle of a burst waits for that burst to finish. The next winner is chosen from the requests present in the cycle the done strobe is seen. The winner is presented as a one-hot grant vector, a channel index and a valid flag. The block does no bus signalling of its own.

Top module: `chan_arb_top`

## Requirements
- R1: After reset, `grant` is all zero, `grant_vld` is low and `grant_idx` is 0.
- R2: While no grant is held, the requesting channel with the highest effective priority receives the grant on the next rising clock edge. A priority value p counts as p, with 5 the highest and 0 the lowest.
- R3: Among requesters that share the top effective priority, the lowest-numbered channel wins.
- R4: A priority field holding 6 or 7 is treated exactly as 5.
- R5: While a grant is held and `xfer_done` is low, `grant`, `grant_idx` and `grant_vld` stay unchanged, whatever happens on `req` and `prio`. This holds even if the granted channel drops its request or a more urgent channel raises one.
- R6: On the rising edge where `xfer_done` is high during a held grant, the arbiter re-arbitrates under the R2 to R4 rules using that cycle's requests. The new grant is visible after that edge and may go to the same channel again.
- R7: If `xfer_done` is high during a held grant and no request is pending, the grant is released on that edge: `grant` becomes zero, `grant_vld` goes low and `grant_idx` becomes 0.
- R8: `xfer_done` has no effect while no grant is held. With no requests, the arbiter stays idle.
- R9: `grant` is zero or one-hot at all times. When `grant_vld` is high, the only set bit of `grant` is the one at position `grant_idx`. `grant_vld` equals the OR of `grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 6 | Per-channel request, bit i is channel i |
| prio | input | 18 | Per-channel priority, bits [3i+2:3i] belong to channel i |
| xfer_done | input | 1 | Pulse marking completion of the current beat or burst |
| grant | output | 6 | One-hot grant, bit i is channel i |
| grant_idx | output | 3 | Index of the granted channel, 0 when nothing is granted |
| grant_vld | output | 1 | High while a channel holds the port |

## Verification
Each decision is due exactly one rising edge after the inputs that cause it are present. This applies to a first grant from idle, to a re-arbitration or release on a done strobe, and to the idle hold under a stray strobe. During a held grant, every output must also keep its value across every edge that has no strobe. The bench changes inputs on the falling edge, lets one rising edge pass and compares the outputs on the following falling edge. It does this against a winner it computes from the request and priority values, so each comparison sees only the effect of that one edge. Hold checks change requests and priorities to an adversarial pattern and confirm that the outputs have not moved.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;

  // Saturate a raw priority code to the highest legal level.
  function automatic logic [7:0] prio_sat(input logic [7:0] raw, input logic [7:0] top);
    return (raw > top) ? top : raw;
  endfunction

endpackage

// File: rtl/chan_arb_eff.sv
module chan_arb_eff #(
  parameter int unsigned N_CH   = 6,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned PRIO_MAX = 5
) (
  input  logic [N_CH*PRIO_W-1:0] prio_raw,
  output logic [N_CH*PRIO_W-1:0] prio_eff
);
  import chan_arb_pkg::*;

  localparam logic [7:0] TOP = 8'(PRIO_MAX);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_sat
    logic [7:0] wide;
    logic [7:0] sat;
    assign wide = 8'(prio_raw[ch*PRIO_W +: PRIO_W]);
    assign sat  = prio_sat(wide, TOP);
    assign prio_eff[ch*PRIO_W +: PRIO_W] = sat[PRIO_W-1:0];
  end
endmodule

// File: rtl/chan_arb_pick.sv
module chan_arb_pick #(
  parameter int unsigned N_CH   = 6,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [N_CH-1:0]        req,
  input  logic [N_CH*PRIO_W-1:0] prio_eff,
  output logic                   found,
  output logic [IDX_W-1:0]       win_idx
);
  // Linear chain: a later channel replaces the running best only on a
  // strictly higher priority, so ties resolve to the lowest index.
  logic              st_found [0:N_CH];
  logic [PRIO_W-1:0] st_prio  [0:N_CH];
  logic [IDX_W-1:0]  st_idx   [0:N_CH];

  assign st_found[0] = 1'b0;
  assign st_prio[0]  = '0;
  assign st_idx[0]   = '0;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_stage
    logic [PRIO_W-1:0] my_prio;
    logic              take;
    assign my_prio = prio_eff[ch*PRIO_W +: PRIO_W];
    assign take    = req[ch] && (!st_found[ch] || (my_prio > st_prio[ch]));
    assign st_found[ch+1] = st_found[ch] || req[ch];
    assign st_prio[ch+1]  = take ? my_prio : st_prio[ch];
    assign st_idx[ch+1]   = take ? IDX_W'(ch) : st_idx[ch];
  end

  assign found   = st_found[N_CH];
  assign win_idx = st_idx[N_CH];
endmodule

// File: rtl/chan_arb_hold.sv
module chan_arb_hold #(
  parameter int unsigned N_CH  = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             found,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             xfer_done,
  output logic [N_CH-1:0]  grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_vld
);
  localparam logic [N_CH-1:0] ONE = {{(N_CH-1){1'b0}}, 1'b1};

  logic [N_CH-1:0]  grant_q, grant_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             vld_q, vld_d;
  logic             decide_en;

  // A decision point is any idle cycle or the completion of a transfer.
  always_comb begin
    decide_en = !vld_q || xfer_done;
    vld_d     = found;
    idx_d     = found ? win_idx : '0;
    grant_d   = found ? (ONE << win_idx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
    end else if (decide_en) begin
      grant_q <= grant_d;
      idx_q   <= idx_d;
      vld_q   <= vld_d;
    end
  end

  assign grant     = grant_q;
  assign grant_idx = idx_q;
  assign grant_vld = vld_q;
endmodule

// File: rtl/chan_arb_top.sv
module chan_arb_top #(
  parameter int unsigned N_CH     = 6,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned PRIO_MAX = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CH-1:0]             req,
  input  logic [N_CH*PRIO_W-1:0]      prio,
  input  logic                        xfer_done,
  output logic [N_CH-1:0]             grant,
  output logic [$clog2(N_CH)-1:0]     grant_idx,
  output logic                        grant_vld
);
  localparam int unsigned IDX_W = $clog2(N_CH);

  logic [N_CH*PRIO_W-1:0] prio_eff;
  logic                   found;
  logic [IDX_W-1:0]       win_idx;

  chan_arb_eff #(.N_CH(N_CH), .PRIO_W(PRIO_W), .PRIO_MAX(PRIO_MAX)) eff_i (
    .prio_raw (prio),
    .prio_eff (prio_eff)
  );

  chan_arb_pick #(.N_CH(N_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) pick_i (
    .req      (req),
    .prio_eff (prio_eff),
    .found    (found),
    .win_idx  (win_idx)
  );

  chan_arb_hold #(.N_CH(N_CH), .IDX_W(IDX_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .found     (found),
    .win_idx   (win_idx),
    .xfer_done (xfer_done),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_vld (grant_vld)
  );
endmodule

// File: rtl/chan_arb_chk.sv
module chan_arb_chk #(
  parameter int unsigned N_CH = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CH-1:0]         req,
  input logic                    xfer_done,
  input logic [N_CH-1:0]         grant,
  input logic [$clog2(N_CH)-1:0] grant_idx,
  input logic                    grant_vld
);
  localparam logic [N_CH-1:0] ONE = {{(N_CH-1){1'b0}}, 1'b1};

  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_vld_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (|grant));

  assert_idx_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (grant == (ONE << grant_idx)));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !xfer_done) |=> ($stable(grant) && $stable(grant_idx) && grant_vld));

  assert_serve_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!grant_vld || xfer_done) && (|req)) |=> grant_vld);

  assert_release_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!grant_vld || xfer_done) && !(|req)) |=> (!grant_vld && grant_idx == '0));

  assert_granted_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!grant_vld || xfer_done) && (|req)) |=> ((grant & $past(req)) == grant));
endmodule

bind chan_arb_top chan_arb_chk #(.N_CH(N_CH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .xfer_done (xfer_done),
  .grant     (grant),
  .grant_idx (grant_idx),
  .grant_vld (grant_vld)
);

// File: tb/chan_arb_top_tb_top.sv
module chan_arb_top_tb_top;
  localparam int N = 6;
  localparam int PW = 3;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [N*PW-1:0] prio;
  logic          xfer_done;
  logic [N-1:0]  grant;
  logic [2:0]    grant_idx;
  logic          grant_vld;

  int checks;
  int errors;

  chan_arb_top dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .xfer_done(xfer_done),
    .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Winner by the requirement rules: levels 6,7 count as 5, ties to low index.
  function automatic int exp_win(input logic [N-1:0] r, input logic [N*PW-1:0] p);
    int best_p;
    int best_i;
    best_p = -1;
    best_i = -1;
    for (int ch = 0; ch < N; ch++) begin
      int e;
      e = int'(p[ch*PW +: PW]);
      if (e > 5) e = 5;
      if (r[ch] && e > best_p) begin
        best_p = e;
        best_i = ch;
      end
    end
    return best_i;
  endfunction

  task automatic expect_state(input int win, input string tag);
    logic [N-1:0] eg;
    logic [2:0]   ei;
    logic         ev;
    eg = (win >= 0) ? (N'(1) << win) : '0;
    ei = (win >= 0) ? 3'(win) : 3'd0;
    ev = (win >= 0);
    checks++;
    if (grant !== eg || grant_idx !== ei || grant_vld !== ev) begin
      errors++;
      $display("FAIL %s: grant=%b idx=%0d vld=%b expected grant=%b idx=%0d vld=%b",
               tag, grant, grant_idx, grant_vld, eg, ei, ev);
    end
  endtask

  // Drive on falling edge, one rising edge passes, sample on next falling edge.
  task automatic cycle(input logic [N-1:0] r, input logic [N*PW-1:0] p, input logic d);
    req = r;
    prio = p;
    xfer_done = d;
    @(negedge clk);
  endtask

  function automatic logic [N*PW-1:0] make_prio(input int cfg);
    logic [N*PW-1:0] v;
    for (int ch = 0; ch < N; ch++) begin
      if (cfg == 7) v[ch*PW +: PW] = 3'd2;
      else if (cfg == 6) v[ch*PW +: PW] = 3'(7 - (ch % 3));
      else v[ch*PW +: PW] = 3'((ch * 3 + cfg * 5) % 8);
    end
    return v;
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req = '0;
    prio = '0;
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    expect_state(-1, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    expect_state(-1, "R1 idle after reset");

    // R8: stray done strobes while idle with no requests
    for (int k = 0; k < 3; k++) begin
      cycle('0, make_prio(0), 1'b1);
      expect_state(-1, "R8 done while idle");
    end

    for (int cfg = 0; cfg < 8; cfg++) begin
      logic [N*PW-1:0] p;
      p = make_prio(cfg);
      for (int r = 1; r < 64; r++) begin
        int w;
        int w2;
        logic [N-1:0] r2;
        w = exp_win(N'(r), p);
        // R2/R3/R4: first grant from idle
        cycle(N'(r), p, 1'b0);
        expect_state(w, "R2 R3 R4 grant from idle");
        // R5: hold against adversarial change, granted channel withdrawn
        cycle(~N'(r), {N{3'd5}}, 1'b0);
        expect_state(w, "R5 hold while busy");
        cycle(N'(1) << ((w + 1) % N), {N{3'd7}}, 1'b0);
        expect_state(w, "R5 hold after second change");
        // R6: re-arbitrate at done with a rotated request set
        r2 = N'((r * 5 + cfg) % 64);
        w2 = exp_win(r2, p);
        cycle(r2, p, 1'b1);
        expect_state(w2, "R6 rearbitrate at done");
        // R7: release with nothing pending
        if (w2 >= 0) begin
          cycle('0, p, 1'b1);
          expect_state(-1, "R7 release at done");
        end
        // R8: done while idle has no effect
        cycle('0, p, 1'b1);
        expect_state(-1, "R8 done while idle in sweep");
      end
    end

    // R6: same channel may win again back to back
    cycle(6'b000100, make_prio(7), 1'b0);
    expect_state(2, "R6 setup");
    cycle(6'b000100, make_prio(7), 1'b1);
    expect_state(2, "R6 same channel regrant");
    cycle('0, make_prio(7), 1'b1);
    expect_state(-1, "R7 final release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule